// File: doc/BRIEF.md
# Strap-Latched Clock Divider Network

This block turns one fast source clock into the family of divided clock outputs of a clock generator: a CPU clock, a 66 MHz group, a buffered 66 MHz group, a PCI clock, a reference clock, a 48 MHz clock and one shared output that carries either the 66 MHz or the 48 MHz waveform. Every output is a square wave built by a counter on the same source clock. All counters start from a common reset point, so the outputs keep a fixed phase relation to each other. A clock-level output is high or low for a whole number of source cycles, called its half period.

Two strap inputs set the operating mode. The strap levels are captured on the first source edge that sees the active-low power-good strobe low. After that capture the strobe and the straps no longer matter. The upper strap is a three-level pin, already decoded into two bits. A low level selects the internal 66 MHz source. A high level selects buffered mode: the buffered 66 MHz group repeats an external 66 MHz input, and PCI runs at half that input's rate. The middle level selects a test mode in which every output is a fixed division of the source clock. In test mode the source clock is taken to run at twice the test clock, so the reference output equals the test clock. The lower strap picks the CPU rate. Until the straps are captured, every divider is held in reset.

A control input steers the shared output between the 66 MHz and 48 MHz sources. The switch never produces a shortened pulse. It waits for the old source to be low, parks the output low, and releases it only after the new source has completed a high phase and fallen.

Top module: `strap_clk_divider`

## Requirements
- R1: After reset, and until the first edge that samples `pwrgd_n` low, `straps_locked`, `s2_bit`, `s1_bit` and all seven clock outputs are 0, whatever the straps do.
- R2: On the first edge that samples `pwrgd_n` low, `s2_lvl` and `s1_in` are captured and `straps_locked` reads 1 from the next cycle on. Later values of `pwrgd_n`, `s2_lvl` and `s1_in` change neither the status bits nor any output.
- R3: The `s2_lvl` encoding is 2'b00 low, 2'b01 high, 2'b10 middle (test mode), and 2'b11 handled as low. `s2_bit` reads 1 only when high was latched, so a latched middle level reads 0. `s1_bit` reads the latched `s1_in`.
- R4: Let n be the number of rising source edges after the capturing edge, with half period h. Each divider output then equals (n / h) mod 2, so every divider is low right after capture and all share one phase reference.
- R5: Outside test mode, the CPU half period is `H_CPU100` when the latched `s1_in` is 0 and `H_CPU133` when it is 1.
- R6: In internal mode (`s2_lvl` low), `clk66_out` and `buf66_out` have half period `H_66` and `pci_out` has half period 2*`H_66`.
- R7: In buffered mode (`s2_lvl` high), `buf66_out` equals `ext66_in` delayed by one register. `pci_out` inverts one cycle after each rising edge of that registered copy, which divides the external clock by 2. `clk66_out` stays on the internal source.
- R8: Outside test mode, `ref_out` has half period `H_REF` and `usb48_out` has half period `H_48`.
- R9: In test mode the half periods are fixed: CPU 2, the 66 MHz group 4, PCI 8, reference 1 and 48 MHz 2.
- R10: With the switch settled, `shared_out` equals the 66 MHz source (`vch_sel` = 0) or the 48 MHz source (`vch_sel` = 1), one cycle late.
- R11: Every high pulse of `shared_out` lasts one full high half of one source. Every low pulse, including one that spans a switch, lasts at least the shorter of the two half periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock for all dividers |
| rst | input | 1 | Synchronous active-high reset |
| pwrgd_n | input | 1 | Active-low power-good strobe that triggers strap capture |
| s2_lvl | input | 2 | Decoded three-level mode strap |
| s1_in | input | 1 | CPU rate strap |
| ext66_in | input | 1 | External 66 MHz clock level, sampled on `clk` |
| vch_sel | input | 1 | Shared output source: 0 = 66 MHz, 1 = 48 MHz |
| straps_locked | output | 1 | Straps captured |
| s2_bit | output | 1 | Latched mode strap as a status bit |
| s1_bit | output | 1 | Latched CPU rate strap |
| cpu_clk | output | 1 | CPU clock |
| clk66_out | output | 1 | Internal 66 MHz group |
| buf66_out | output | 1 | Buffered 66 MHz group |
| pci_out | output | 1 | PCI clock |
| ref_out | output | 1 | Reference clock |
| usb48_out | output | 1 | 48 MHz clock |
| shared_out | output | 1 | Shared 66/48 MHz output |

## Verification
The assertions check the following on every cycle: outputs stay silent before capture, the capture and its status bits never change afterwards, a latched middle level reads 0, the buffered output tracks the external input, PCI inverts only after an external rising edge, and the reference toggles every cycle in test mode. They also check that the shared output rises or falls only one cycle after its current source does, which rules out a truncated pulse. The bench scenarios cover the exact half period of each output in each strap setting, the common starting phase after capture, and the lengths of the low gaps when the shared output changes source.

// File: rtl/strapdiv_pkg.sv
package strapdiv_pkg;

    typedef enum logic [1:0] {
        MODE_INT  = 2'd0,
        MODE_BUF  = 2'd1,
        MODE_TEST = 2'd2
    } div_mode_e;

    typedef enum logic [1:0] {
        VS_RUN  = 2'd0,
        VS_STOP = 2'd1,
        VS_WAIT = 2'd2
    } vch_state_e;

    typedef struct packed {
        div_mode_e mode;
        logic      s1;
        logic      s2_high;
    } strap_t;

    localparam int NUM_DIV = 5;
    localparam int DIV_CPU = 0;
    localparam int DIV_66  = 1;
    localparam int DIV_PCI = 2;
    localparam int DIV_REF = 3;
    localparam int DIV_48  = 4;

    localparam int TEST_HALF_CPU = 2;
    localparam int TEST_HALF_66  = 4;
    localparam int TEST_HALF_PCI = 8;
    localparam int TEST_HALF_REF = 1;
    localparam int TEST_HALF_48  = 2;

    function automatic div_mode_e decode_s2(input logic [1:0] lvl);
        case (lvl)
            2'b01:   return MODE_BUF;
            2'b10:   return MODE_TEST;
            default: return MODE_INT;
        endcase
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int pick_half(input div_mode_e m, input logic s1, input int idx,
                                     input int h100, input int h133, input int h66,
                                     input int href, input int h48);
        logic tst;
        tst = (m == MODE_TEST);
        case (idx)
            DIV_CPU: return tst ? TEST_HALF_CPU : (s1 ? h133 : h100);
            DIV_66:  return tst ? TEST_HALF_66 : h66;
            DIV_PCI: return tst ? TEST_HALF_PCI : 2 * h66;
            DIV_REF: return tst ? TEST_HALF_REF : href;
            default: return tst ? TEST_HALF_48 : h48;
        endcase
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strapdiv_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pwrgd_n,
    input  logic [1:0] s2_lvl,
    input  logic       s1_in,
    output strap_t     strap_o,
    output logic       locked_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            locked_o        <= 1'b0;
            strap_o.mode    <= MODE_INT;
            strap_o.s1      <= 1'b0;
            strap_o.s2_high <= 1'b0;
        end else if (!locked_o && !pwrgd_n) begin
            locked_o        <= 1'b1;
            strap_o.mode    <= decode_s2(s2_lvl);
            strap_o.s1      <= s1_in;
            strap_o.s2_high <= (s2_lvl == 2'b01);
        end
    end
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] half,
    output logic             div_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt   <= '0;
            div_o <= 1'b0;
        end else if (cnt == half - ONE) begin
            cnt   <= '0;
            div_o <= ~div_o;
        end else begin
            cnt <= cnt + ONE;
        end
    end
endmodule

// File: rtl/vch_switch.sv
module vch_switch
    import strapdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sel_req,
    input  logic src_a,
    input  logic src_b,
    output logic cur_sel,
    output logic clk_o
);
    vch_state_e st;
    logic       seen_high;
    logic       cur_src;

    assign cur_src = cur_sel ? src_b : src_a;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= VS_RUN;
            cur_sel   <= 1'b0;
            clk_o     <= 1'b0;
            seen_high <= 1'b0;
        end else if (!en) begin
            st        <= VS_RUN;
            cur_sel   <= sel_req;
            clk_o     <= 1'b0;
            seen_high <= 1'b0;
        end else begin
            case (st)
                VS_RUN: begin
                    clk_o <= cur_src;
                    if (sel_req != cur_sel && !cur_src)
                        st <= VS_STOP;
                end
                VS_STOP: begin
                    clk_o     <= 1'b0;
                    cur_sel   <= sel_req;
                    seen_high <= 1'b0;
                    st        <= VS_WAIT;
                end
                VS_WAIT: begin
                    clk_o <= 1'b0;
                    if (sel_req != cur_sel)
                        st <= VS_STOP;
                    else if (cur_src)
                        seen_high <= 1'b1;
                    else if (seen_high)
                        st <= VS_RUN;
                end
                default: st <= VS_RUN;
            endcase
        end
    end
endmodule

// File: rtl/strap_clk_divider.sv
module strap_clk_divider
    import strapdiv_pkg::*;
#(
    parameter int H_CPU100 = 4,
    parameter int H_CPU133 = 3,
    parameter int H_66     = 6,
    parameter int H_REF    = 14,
    parameter int H_48     = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwrgd_n,
    input  logic [1:0] s2_lvl,
    input  logic       s1_in,
    input  logic       ext66_in,
    input  logic       vch_sel,
    output logic       straps_locked,
    output logic       s2_bit,
    output logic       s1_bit,
    output logic       cpu_clk,
    output logic       clk66_out,
    output logic       buf66_out,
    output logic       pci_out,
    output logic       ref_out,
    output logic       usb48_out,
    output logic       shared_out
);
    localparam int H_NORM_MAX = max2(max2(max2(H_CPU100, H_CPU133), max2(2 * H_66, H_REF)), H_48);
    localparam int H_MAX      = max2(H_NORM_MAX, TEST_HALF_PCI);
    localparam int CNT_W      = $clog2(H_MAX + 1);

    strap_t           strap_q;
    logic             locked_q;
    div_mode_e        cur_mode;
    logic [CNT_W-1:0] half_w [NUM_DIV];
    logic [NUM_DIV-1:0] div_w;
    logic             ext_q;
    logic             ext_qq;
    logic             pci_b;
    logic             vch_cur;
    logic             vch_y;

    strap_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .pwrgd_n (pwrgd_n),
        .s2_lvl  (s2_lvl),
        .s1_in   (s1_in),
        .strap_o (strap_q),
        .locked_o(locked_q)
    );

    assign cur_mode = strap_q.mode;

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        assign half_w[g] = CNT_W'(pick_half(cur_mode, strap_q.s1, g,
                                            H_CPU100, H_CPU133, H_66, H_REF, H_48));
        clkdiv_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .en   (locked_q),
            .half (half_w[g]),
            .div_o(div_w[g])
        );
    end

    // external 66 MHz path: one sampling register plus an edge history stage
    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q  <= 1'b0;
            ext_qq <= 1'b0;
        end else begin
            ext_q  <= ext66_in;
            ext_qq <= ext_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !locked_q)
            pci_b <= 1'b0;
        else if (cur_mode == MODE_BUF && ext_q && !ext_qq)
            pci_b <= ~pci_b;
    end

    vch_switch u_vch (
        .clk    (clk),
        .rst    (rst),
        .en     (locked_q),
        .sel_req(vch_sel),
        .src_a  (div_w[DIV_66]),
        .src_b  (div_w[DIV_48]),
        .cur_sel(vch_cur),
        .clk_o  (vch_y)
    );

    assign straps_locked = locked_q;
    assign s2_bit        = strap_q.s2_high;
    assign s1_bit        = strap_q.s1;
    assign cpu_clk       = div_w[DIV_CPU];
    assign clk66_out     = div_w[DIV_66];
    assign buf66_out     = (cur_mode == MODE_BUF) ? (locked_q & ext_q) : div_w[DIV_66];
    assign pci_out       = (cur_mode == MODE_BUF) ? pci_b : div_w[DIV_PCI];
    assign ref_out       = div_w[DIV_REF];
    assign usb48_out     = div_w[DIV_48];
    assign shared_out    = vch_y;
endmodule

// File: rtl/strap_clk_divider_chk.sv
module strap_clk_divider_chk
    import strapdiv_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      locked,
    input div_mode_e mode,
    input logic      s1_bit,
    input logic      s2_bit,
    input logic      ext66_in,
    input logic      ext_q,
    input logic      ext_qq,
    input logic      cpu_clk,
    input logic      clk66_out,
    input logic      buf66_out,
    input logic      pci_out,
    input logic      ref_out,
    input logic      usb48_out,
    input logic      shared_out,
    input logic      vch_cur
);
    logic src_now;
    assign src_now = vch_cur ? usb48_out : clk66_out;

    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !locked |-> ({cpu_clk, clk66_out, buf66_out, pci_out, ref_out, usb48_out, shared_out} == 7'd0
                     && !s2_bit && !s1_bit));

    p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        locked |=> (locked && $stable(s1_bit) && $stable(s2_bit)));

    p_mid_reads_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (locked && mode == MODE_TEST) |-> !s2_bit);

    p_common_start_r4: assert property (@(posedge clk) disable iff (rst)
        (locked && !$past(locked)) |-> ({cpu_clk, clk66_out, pci_out, ref_out, usb48_out} == 5'd0));

    p_buf_follow_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && mode == MODE_BUF) |-> (buf66_out == $past(ext66_in)));

    p_pci_edge_r7: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked) && mode == MODE_BUF && pci_out != $past(pci_out))
            |-> ($past(ext_q) && !$past(ext_qq)));

    p_ref_test_r9: assert property (@(posedge clk) disable iff (rst)
        (locked && $past(locked) && mode == MODE_TEST) |-> (ref_out != $past(ref_out)));

    p_rise_full_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(shared_out) |-> ($past(src_now) && !$past(src_now, 2)));

    p_fall_full_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(shared_out) |-> (!$past(src_now) && $past(src_now, 2)));
endmodule

bind strap_clk_divider strap_clk_divider_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .locked    (locked_q),
    .mode      (cur_mode),
    .s1_bit    (s1_bit),
    .s2_bit    (s2_bit),
    .ext66_in  (ext66_in),
    .ext_q     (ext_q),
    .ext_qq    (ext_qq),
    .cpu_clk   (cpu_clk),
    .clk66_out (clk66_out),
    .buf66_out (buf66_out),
    .pci_out   (pci_out),
    .ref_out   (ref_out),
    .usb48_out (usb48_out),
    .shared_out(shared_out),
    .vch_cur   (vch_cur)
);

// File: tb/strap_clk_divider_tb_top.sv
`timescale 1ns/1ps
module strap_clk_divider_tb_top;

    localparam int B_H100 = 4;
    localparam int B_H133 = 3;
    localparam int B_H66  = 6;
    localparam int B_HREF = 14;
    localparam int B_H48  = 8;
    localparam int NCYC   = 130;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwrgd_n = 1'b1;
    logic [1:0] s2_lvl = 2'b00;
    logic       s1_in = 1'b0;
    logic       ext66_in = 1'b0;
    logic       vch_sel = 1'b0;
    logic       straps_locked, s2_bit, s1_bit;
    logic       cpu_clk, clk66_out, buf66_out, pci_out, ref_out, usb48_out, shared_out;

    int n_checks = 0;
    int n_err    = 0;

    always #2.5 clk = ~clk;

    strap_clk_divider #(
        .H_CPU100(B_H100), .H_CPU133(B_H133), .H_66(B_H66), .H_REF(B_HREF), .H_48(B_H48)
    ) dut_i (
        .clk(clk), .rst(rst), .pwrgd_n(pwrgd_n), .s2_lvl(s2_lvl), .s1_in(s1_in),
        .ext66_in(ext66_in), .vch_sel(vch_sel), .straps_locked(straps_locked),
        .s2_bit(s2_bit), .s1_bit(s1_bit), .cpu_clk(cpu_clk), .clk66_out(clk66_out),
        .buf66_out(buf66_out), .pci_out(pci_out), .ref_out(ref_out),
        .usb48_out(usb48_out), .shared_out(shared_out)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // md: 0 internal, 1 buffered, 2 test; idx: 0 cpu, 1 66, 2 pci, 3 ref, 4 48
    function automatic int bhalf(input int md, input bit s1v, input int idx);
        if (md == 2) begin
            case (idx)
                0: return 2;
                1: return 4;
                2: return 8;
                3: return 1;
                default: return 2;
            endcase
        end
        case (idx)
            0: return s1v ? B_H133 : B_H100;
            1: return B_H66;
            2: return 2 * B_H66;
            3: return B_HREF;
            default: return B_H48;
        endcase
    endfunction

    function automatic int mode_of(input logic [1:0] lvl);
        return (lvl == 2'b01) ? 1 : ((lvl == 2'b10) ? 2 : 0);
    endfunction

    function automatic string tag_of(input int k, input int md);
        if (md == 2) return (k == 6) ? "R10" : "R4/R9";
        case (k)
            0: return "R4/R5 cpu";
            1: return "R6 clk66";
            2: return (md == 1) ? "R7 buf66" : "R6 buf66";
            3: return (md == 1) ? "R7 pci" : "R6 pci";
            4: return "R8 ref";
            5: return "R8 usb48";
            default: return "R10 shared";
        endcase
    endfunction

    task automatic do_reset(input bit vsel);
        rst = 1'b1; pwrgd_n = 1'b1; vch_sel = vsel; ext66_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic lock_straps(input logic [1:0] lvl, input bit s1v);
        int pre_err;
        pre_err = 0;
        repeat (5) begin
            s2_lvl = 2'($urandom);
            s1_in  = 1'($urandom);
            @(negedge clk);
            if ({cpu_clk, clk66_out, buf66_out, pci_out, ref_out, usb48_out, shared_out} != 7'd0
                || straps_locked || s2_bit || s1_bit)
                pre_err++;
        end
        chk(pre_err == 0, "R1", "silent before capture (bad cycles)", pre_err, 0);
        s2_lvl = lvl; s1_in = s1v; pwrgd_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_scn(input logic [1:0] lvl, input bit s1v, input bit vsel);
        int md, rl, stat_err;
        int h[5];
        int err_o[7], fn[7], fa[7], fe[7];
        bit obs[7], ex[7];
        bit e1, e2, e3, ev, pci_e, s2_exp;
        md = mode_of(lvl);
        for (int k = 0; k < 5; k++) h[k] = bhalf(md, s1v, k);
        for (int k = 0; k < 7; k++) begin err_o[k] = 0; fn[k] = 0; fa[k] = 0; fe[k] = 0; end
        s2_exp = (lvl == 2'b01);
        do_reset(vsel);
        lock_straps(lvl, s1v);
        chk(straps_locked == 1'b1, "R2", "locked after strobe low", int'(straps_locked), 1);
        chk(s2_bit == s2_exp, "R3", "latched s2 status", int'(s2_bit), int'(s2_exp));
        chk(s1_bit == s1v, "R3", "latched s1 status", int'(s1_bit), int'(s1v));
        e1 = 0; e2 = 0; e3 = 0; ev = 0; pci_e = 0; rl = 0; stat_err = 0;
        ext66_in = 1'b0;
        pwrgd_n = 1'($urandom); s2_lvl = 2'($urandom); s1_in = 1'($urandom);
        for (int n = 1; n <= NCYC; n++) begin
            @(negedge clk);
            obs[0] = cpu_clk; obs[1] = clk66_out; obs[2] = buf66_out; obs[3] = pci_out;
            obs[4] = ref_out; obs[5] = usb48_out; obs[6] = shared_out;
            pci_e = pci_e ^ (e2 & ~e3);
            ex[0] = ((n / h[0]) % 2) == 1;
            ex[1] = ((n / h[1]) % 2) == 1;
            ex[2] = (md == 1) ? e1 : ex[1];
            ex[3] = (md == 1) ? pci_e : (((n / h[2]) % 2) == 1);
            ex[4] = ((n / h[3]) % 2) == 1;
            ex[5] = ((n / h[4]) % 2) == 1;
            ex[6] = (((n - 1) / (vsel ? h[4] : h[1])) % 2) == 1;
            for (int k = 0; k < 7; k++) begin
                if (obs[k] != ex[k]) begin
                    if (err_o[k] == 0) begin fn[k] = n; fa[k] = int'(obs[k]); fe[k] = int'(ex[k]); end
                    err_o[k]++;
                end
            end
            if (!straps_locked || s2_bit != s2_exp || s1_bit != s1v) stat_err++;
            // R2: strobe and straps toggle freely after capture
            pwrgd_n = 1'($urandom); s2_lvl = 2'($urandom); s1_in = 1'($urandom);
            if (n < 3) ev = 1'b0;
            else if (rl == 0) begin ev = ~ev; rl = 1 + int'($urandom % 4); end
            else rl--;
            ext66_in = ev;
            e3 = e2; e2 = e1; e1 = ev;
        end
        chk(stat_err == 0, "R2", "status held after capture (bad cycles)", stat_err, 0);
        for (int k = 0; k < 7; k++) begin
            if (err_o[k] != 0)
                $display("  first mismatch of output %0d at cycle %0d", k, fn[k]);
            chk(err_o[k] == 0, tag_of(k, md), "waveform value at first mismatch", fa[k], fe[k]);
        end
    endtask

    task automatic run_switch(input logic [1:0] lvl);
        int md, h66, h48, run, tgt;
        bit prev, y, seen_rise, settled;
        md  = mode_of(lvl);
        h66 = bhalf(md, 1'b0, 1);
        h48 = bhalf(md, 1'b0, 4);
        do_reset(1'b0);
        lock_straps(lvl, 1'b0);
        prev = 0; run = 1; seen_rise = 0; settled = 0;
        tgt = h48;
        for (int n = 1; n <= 1600; n++) begin
            @(negedge clk);
            y = shared_out;
            if (y == prev) run++;
            else begin
                if (prev) begin
                    if (settled)
                        chk(run == tgt, "R10", "settled high pulse length", run, tgt);
                    else
                        chk(run == h66 || run == h48, "R11", "high pulse is a full source half", run, h66);
                end else if (seen_rise) begin
                    chk(run >= ((h66 < h48) ? h66 : h48), "R11", "low gap not shortened", run,
                        (h66 < h48) ? h66 : h48);
                end
                if (y) seen_rise = 1;
                prev = y;
                run = 1;
            end
            if (n < 1200) begin
                if ($urandom % 25 == 0) vch_sel = ~vch_sel;
            end else if (n == 1200) vch_sel = 1'b1;
            if (n == 1300) settled = 1;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        chk(straps_locked == 1'b0 && shared_out == 1'b0 && cpu_clk == 1'b0, "R1",
            "reset state", int'(straps_locked), 0);
        run_scn(2'b00, 1'b0, 1'b0);
        run_scn(2'b00, 1'b1, 1'b1);
        run_scn(2'b01, 1'b0, 1'b0);
        run_scn(2'b01, 1'b1, 1'b1);
        run_scn(2'b10, 1'b1, 1'b0);
        run_scn(2'b10, 1'b0, 1'b1);
        run_scn(2'b11, 1'b0, 1'b1);
        run_switch(2'b00);
        run_switch(2'b10);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule